// File: doc/BRIEF.md
# Operand Address Resolver

This block sits between the instruction decoder and the memories of an 8-bit microcontroller data path. Each cycle it receives an operand request (an addressing mode with the fields that go with it) and turns it into a physical location. The location has a target space (internal RAM, the special-register space, code memory, or nothing) and an address. A flag marks requests that point at nothing legal. The result is registered, so it appears one cycle after the request.

The block covers five modes:

- **Register mode** maps R0 to R7 into a RAM window. The window is chosen by the two bank-select bits.
- **Direct mode** splits its byte address at 80H. Lower addresses go to RAM and upper addresses go to the special registers.
- **Register-indirect mode** points through R0 or R1 only. It needs the pointer's value, which the data path reads from the banked RAM location that this block gives combinationally on `ptr_loc`. The data path returns that value on `ptr_val` in the same cycle.
- **Immediate mode** needs no memory access.
- **Indexed code mode** adds the accumulator to the 16-bit data pointer.

Top module: `opr_resolver`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs become space NONE (code 0), address 0000H and illegal 0.
- R2: Mode code 1 (register) yields space RAM (code 1) and address bank*8 + index one cycle later, for every bank 0 to 3. Bank 2 with R7 gives 0017H.
- R3: Mode code 2 (direct) with an address from 00H to 7FH yields space RAM and that same address, with illegal 0.
- R4: Mode code 2 with an address from 80H to FFH yields space SFR (code 2) and that address. The illegal flag stays 0 for these implemented locations: 80H, 81H, 82H, 83H, 90H, A0H, B0H, D0H, E0H and F0H.
- R5: Mode code 2 with any other address from 80H upward still yields space SFR and the address, but raises illegal.
- R6: `ptr_loc` combinationally shows bank*8 + index bit 0. Mode code 3 (indirect) with index 0 or 1 yields space RAM and address `ptr_val` one cycle later.
- R7: Mode code 3 with index 2 to 7 yields space NONE, address 0 and illegal 1.
- R8: Mode code 4 (indexed) yields space CODE (code 3) and address (acc + dptr) modulo 65536.
- R9: Mode code 0 (immediate) yields space NONE, address 0 and illegal 0.
- R10: Mode codes 5 to 7 yield space NONE, address 0 and illegal 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Addressing mode code |
| reg_idx | input | 3 | Register number for register or indirect mode |
| dir_addr | input | 8 | Byte address for direct mode |
| bank_sel | input | 2 | Active register bank |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer, high byte first |
| ptr_val | input | 8 | Value read from the pointer register's RAM location |
| ptr_loc | output | 8 | RAM location of the indirect pointer register |
| space | output | 2 | Target space: 0 none, 1 RAM, 2 SFR, 3 code |
| addr | output | 16 | Resolved address |
| illegal | output | 1 | Request targets no legal location |

## Verification
The hardest cases to reach are at the edges of the special-register map and of the sum. These are the gaps between implemented locations (84H, FFH), the very top of the map, and an indexed sum that carries out of 16 bits. The vector table aims directly at each one, next to its legal neighbours (83H, F0H). The indirect handshake also needs care, because `ptr_loc` is combinational and the pointer value returns in the same cycle. The bench checks `ptr_loc` before the clock edge and checks the registered address after it. It does this in several banks, so a pointer taken from the wrong bank would show up.

// File: rtl/opr_pkg.sv
// Shared types for the operand address resolver.
// Assumes the mode and space encodings below are shared with the decoder.
package opr_pkg;
    typedef enum logic [2:0] {
        MODE_IMM = 3'd0,
        MODE_REG = 3'd1,
        MODE_DIR = 3'd2,
        MODE_IND = 3'd3,
        MODE_IDX = 3'd4
    } opr_mode_e;

    typedef enum logic [1:0] {
        SPC_NONE = 2'd0,
        SPC_RAM  = 2'd1,
        SPC_SFR  = 2'd2,
        SPC_CODE = 2'd3
    } opr_space_e;
endpackage

// File: rtl/opr_bank_map.sv
// Maps a register number into the banked RAM window.
// Assumes that DATA_W is at least BANK_W + REG_W.
module opr_bank_map #(
    parameter int DATA_W = 8,
    parameter int BANK_W = 2,
    parameter int REG_W  = 3
) (
    input  logic [BANK_W-1:0] bank,
    input  logic [REG_W-1:0]  idx,
    output logic [DATA_W-1:0] loc
);
    localparam int PAD_W = DATA_W - BANK_W - REG_W;

    // Place the bank above the register number: bank*8 + n.
    always_comb begin
        loc = {{PAD_W{1'b0}}, bank, idx};
    end
endmodule

// File: rtl/opr_sfr_check.sv
// Reports whether an upper-half byte address is an implemented special register.
// Assumes the caller only uses the result when address bit 7 is set.
module opr_sfr_check #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] sfr_addr,
    output logic              known
);
    localparam int N_SFR = 10;
    localparam logic [DATA_W-1:0] SFR_LIST [N_SFR] = '{
        DATA_W'(8'h80), DATA_W'(8'h81), DATA_W'(8'h82), DATA_W'(8'h83),
        DATA_W'(8'h90), DATA_W'(8'hA0), DATA_W'(8'hB0), DATA_W'(8'hD0),
        DATA_W'(8'hE0), DATA_W'(8'hF0)
    };

    logic [N_SFR-1:0] hit;

    // One comparator per implemented location.
    for (genvar g = 0; g < N_SFR; g++) begin : g_cmp
        assign hit[g] = (sfr_addr == SFR_LIST[g]);
    end

    // Any match means the location exists.
    always_comb begin
        known = |hit;
    end
endmodule

// File: rtl/opr_index_add.sv
// Forms the indexed code address as accumulator plus data pointer.
// Assumes that the sum wraps at the code address width.
module opr_index_add #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 16
) (
    input  logic [DATA_W-1:0] acc,
    input  logic [CODE_W-1:0] base,
    output logic [CODE_W-1:0] sum
);
    // Unsigned add with the carry out discarded.
    always_comb begin
        sum = base + CODE_W'(acc);
    end
endmodule

// File: rtl/opr_resolver.sv
// Top of the operand address resolver. It registers the resolved space,
// address and illegal flag one cycle after the request, and drives the
// pointer register's RAM location combinationally for indirect mode.
// Assumes ptr_val is returned within the same cycle as ptr_loc.
module opr_resolver #(
    parameter int DATA_W = 8,
    parameter int CODE_W = 16,
    parameter int BANK_W = 2,
    parameter int REG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic [REG_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] dir_addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [DATA_W-1:0] acc,
    input  logic [CODE_W-1:0] dptr,
    input  logic [DATA_W-1:0] ptr_val,
    output logic [DATA_W-1:0] ptr_loc,
    output logic [1:0]        space,
    output logic [CODE_W-1:0] addr,
    output logic              illegal
);
    import opr_pkg::*;

    logic [DATA_W-1:0] reg_loc;
    logic [CODE_W-1:0] idx_sum;
    logic              sfr_known;
    logic              ptr_ok;
    opr_space_e        nxt_space;
    logic [CODE_W-1:0] nxt_addr;
    logic              nxt_ill;

    opr_bank_map #(.DATA_W(DATA_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_reg_map (
        .bank (bank_sel),
        .idx  (reg_idx),
        .loc  (reg_loc)
    );

    opr_bank_map #(.DATA_W(DATA_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_ptr_map (
        .bank (bank_sel),
        .idx  ({{(REG_W-1){1'b0}}, reg_idx[0]}),
        .loc  (ptr_loc)
    );

    opr_sfr_check #(.DATA_W(DATA_W)) u_sfr (
        .sfr_addr (dir_addr),
        .known    (sfr_known)
    );

    opr_index_add #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_add (
        .acc  (acc),
        .base (dptr),
        .sum  (idx_sum)
    );

    // Only R0 and R1 may act as pointers.
    always_comb begin
        ptr_ok = (reg_idx[REG_W-1:1] == '0);
    end

    // Pick the location for the requested mode.
    always_comb begin
        nxt_space = SPC_NONE;
        nxt_addr  = '0;
        nxt_ill   = 1'b0;
        case (mode)
            MODE_IMM: ;
            MODE_REG: begin
                nxt_space = SPC_RAM;
                nxt_addr  = CODE_W'(reg_loc);
            end
            MODE_DIR: begin
                nxt_addr = CODE_W'(dir_addr);
                if (dir_addr[DATA_W-1]) begin
                    nxt_space = SPC_SFR;
                    nxt_ill   = !sfr_known;
                end else begin
                    nxt_space = SPC_RAM;
                end
            end
            MODE_IND: begin
                if (ptr_ok) begin
                    nxt_space = SPC_RAM;
                    nxt_addr  = CODE_W'(ptr_val);
                end else begin
                    nxt_ill = 1'b1;
                end
            end
            MODE_IDX: begin
                nxt_space = SPC_CODE;
                nxt_addr  = idx_sum;
            end
            default: nxt_ill = 1'b1;
        endcase
    end

    // Register the resolved location; clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            space   <= SPC_NONE;
            addr    <= '0;
            illegal <= 1'b0;
        end else begin
            space   <= nxt_space;
            addr    <= nxt_addr;
            illegal <= nxt_ill;
        end
    end

    p_reg_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == MODE_REG) |->
        (space == SPC_RAM && addr == CODE_W'({$past(bank_sel), $past(reg_idx)})));

    p_dir_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == MODE_DIR) |->
        ((space == SPC_SFR) == $past(dir_addr[DATA_W-1]) && addr == CODE_W'($past(dir_addr))));

    p_ind_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == MODE_IND && $past(reg_idx) < 2) |->
        (space == SPC_RAM && addr == CODE_W'($past(ptr_val)) && !illegal));

    p_ind_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == MODE_IND && $past(reg_idx) > 1) |->
        (space == SPC_NONE && illegal));

    p_idx_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == MODE_IDX) |->
        (space == SPC_CODE && addr == CODE_W'($past(dptr) + CODE_W'($past(acc)))));

    p_imm_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == MODE_IMM) |->
        (space == SPC_NONE && !illegal));

    p_ill_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (space == SPC_NONE || space == SPC_SFR));
endmodule

// File: tb/test_opr_resolver.sv
// Vector-table bench for opr_resolver, followed by directed checks.
module test_opr_resolver;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = '0;
    logic [2:0]  reg_idx = '0;
    logic [7:0]  dir_addr = '0;
    logic [1:0]  bank_sel = '0;
    logic [7:0]  acc = '0;
    logic [15:0] dptr = '0;
    logic [7:0]  ptr_val = '0;
    logic [7:0]  ptr_loc;
    logic [1:0]  space;
    logic [15:0] addr;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opr_resolver i_opr_resolver (
        .clk(clk), .rst_n(rst_n), .mode(mode), .reg_idx(reg_idx),
        .dir_addr(dir_addr), .bank_sel(bank_sel), .acc(acc), .dptr(dptr),
        .ptr_val(ptr_val), .ptr_loc(ptr_loc), .space(space), .addr(addr),
        .illegal(illegal)
    );

    typedef struct packed {
        logic [2:0]  md;
        logic [2:0]  ix;
        logic [7:0]  da;
        logic [1:0]  bk;
        logic [7:0]  ac;
        logic [15:0] dp;
        logic [7:0]  pv;
        logic [1:0]  e_sp;
        logic [15:0] e_ad;
        logic        e_il;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 3'd5, 8'h00, 2'd0, 8'h00, 16'h0000, 8'h00, 2'd1, 16'h0005, 1'b0, 8'd2}, // R2
        '{3'd1, 3'd7, 8'h00, 2'd3, 8'h00, 16'h0000, 8'h00, 2'd1, 16'h001F, 1'b0, 8'd2}, // R2
        '{3'd1, 3'd7, 8'h00, 2'd2, 8'h00, 16'h0000, 8'h00, 2'd1, 16'h0017, 1'b0, 8'd2}, // R2
        '{3'd2, 3'd0, 8'h7F, 2'd0, 8'h00, 16'h0000, 8'h00, 2'd1, 16'h007F, 1'b0, 8'd3}, // R3
        '{3'd2, 3'd0, 8'h00, 2'd1, 8'h00, 16'h0000, 8'h00, 2'd1, 16'h0000, 1'b0, 8'd3}, // R3
        '{3'd2, 3'd0, 8'h80, 2'd0, 8'h00, 16'h0000, 8'h00, 2'd2, 16'h0080, 1'b0, 8'd4}, // R4
        '{3'd2, 3'd0, 8'hE0, 2'd0, 8'h00, 16'h0000, 8'h00, 2'd2, 16'h00E0, 1'b0, 8'd4}, // R4
        '{3'd2, 3'd0, 8'hF0, 2'd0, 8'h00, 16'h0000, 8'h00, 2'd2, 16'h00F0, 1'b0, 8'd4}, // R4
        '{3'd2, 3'd0, 8'h83, 2'd0, 8'h00, 16'h0000, 8'h00, 2'd2, 16'h0083, 1'b0, 8'd4}, // R4
        '{3'd2, 3'd0, 8'h84, 2'd0, 8'h00, 16'h0000, 8'h00, 2'd2, 16'h0084, 1'b1, 8'd5}, // R5
        '{3'd2, 3'd0, 8'hFF, 2'd0, 8'h00, 16'h0000, 8'h00, 2'd2, 16'h00FF, 1'b1, 8'd5}, // R5
        '{3'd3, 3'd0, 8'h00, 2'd1, 8'h00, 16'h0000, 8'h40, 2'd1, 16'h0040, 1'b0, 8'd6}, // R6
        '{3'd3, 3'd1, 8'h00, 2'd0, 8'h00, 16'h0000, 8'h7F, 2'd1, 16'h007F, 1'b0, 8'd6}, // R6
        '{3'd3, 3'd2, 8'h00, 2'd0, 8'h00, 16'h0000, 8'h55, 2'd0, 16'h0000, 1'b1, 8'd7}, // R7
        '{3'd4, 3'd0, 8'h00, 2'd0, 8'h05, 16'h0300, 8'h00, 2'd3, 16'h0305, 1'b0, 8'd8}, // R8
        '{3'd4, 3'd0, 8'h00, 2'd0, 8'hFF, 16'hFFF0, 8'h00, 2'd3, 16'h00EF, 1'b0, 8'd8}, // R8
        '{3'd4, 3'd0, 8'h00, 2'd0, 8'h00, 16'h0200, 8'h00, 2'd3, 16'h0200, 1'b0, 8'd8}, // R8
        '{3'd0, 3'd3, 8'h90, 2'd2, 8'h12, 16'h1234, 8'h00, 2'd0, 16'h0000, 1'b0, 8'd9}, // R9
        '{3'd6, 3'd1, 8'h10, 2'd0, 8'h00, 16'h0000, 8'h00, 2'd0, 16'h0000, 1'b1, 8'd10} // R10
    };

    task automatic check_out(input string tag, input logic [1:0] e_sp,
                             input logic [15:0] e_ad, input logic e_il);
        checks++;
        if (space !== e_sp || addr !== e_ad || illegal !== e_il) begin
            errors++;
            $display("FAIL %s: space=%0d addr=%h ill=%b expected space=%0d addr=%h ill=%b",
                     tag, space, addr, illegal, e_sp, e_ad, e_il);
        end
    endtask

    task automatic check_loc(input string tag, input logic [7:0] e_loc);
        checks++;
        if (ptr_loc !== e_loc) begin
            errors++;
            $display("FAIL %s: ptr_loc=%h expected %h", tag, ptr_loc, e_loc);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (2) @(negedge clk);
        check_out("R1 reset", 2'd0, 16'h0000, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mode = VECS[i].md;  reg_idx = VECS[i].ix; dir_addr = VECS[i].da;
            bank_sel = VECS[i].bk; acc = VECS[i].ac; dptr = VECS[i].dp;
            ptr_val = VECS[i].pv;
            @(negedge clk);
            check_out($sformatf("R%0d vec %0d", VECS[i].req, i),
                      VECS[i].e_sp, VECS[i].e_ad, VECS[i].e_il);
        end

        // R6: pointer location tracks bank and index bit 0 combinationally
        @(negedge clk);
        mode = 3'd3; reg_idx = 3'd1; bank_sel = 2'd2; ptr_val = 8'h33;
        #1 check_loc("R6 bank2 R1", 8'h11);
        @(negedge clk);
        check_out("R6 bank2 result", 2'd1, 16'h0033, 1'b0);
        reg_idx = 3'd0; bank_sel = 2'd3;
        #1 check_loc("R6 bank3 R0", 8'h18);

        // R1: reset in mid-run clears a code-space result
        @(negedge clk);
        mode = 3'd4; acc = 8'h10; dptr = 16'h0100;
        @(negedge clk);
        check_out("R8 before reset", 2'd3, 16'h0110, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1 mid-run reset", 2'd0, 16'h0000, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R8 after reset", 2'd3, 16'h0110, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule